// File: doc/BRIEF.md
# Watchdog Timer with Selectable Expiry Action

The block is a bus-attached watchdog. A 32-bit counter counts down by one per clock while an expiry action is selected. When the counter reaches zero it stays at zero, and the block raises the output that the action picks. The choices are no event, a general-purpose interrupt, a non-maskable interrupt, or a request for a full chip reset. Software keeps the system alive by writing a fresh tick count to the timer register before the count runs out.

A timer write does not reach the counter at once. It travels through a short fixed-length settling path, so the count read during that window is still the old one. A reset-cause flag records that the last chip reset came from this watchdog. The block's own reset does not clear that flag; only the power-on reset input does. Software can therefore read the flag after the restart that the watchdog itself caused.

Top module: `action_watchdog`

## Requirements
- R1: After power-on and block reset, the control register reads 0, the timer reads 0, and irq_o, nmi_o and chip_rst_req_o are low.
- R2: The control register is at byte address 0x00. Bits [1:0] hold the action code: 0 = none, 1 = interrupt, 2 = NMI, 3 = chip reset. Bit 31 reads as the reset-cause flag, and every other bit reads 0. A write updates only bits [1:0]; written values of bit 31 and of bits [30:2] are ignored.
- R3: The timer register is at byte address 0x04. The value written there is loaded into the counter on the 4th rising edge after the edge that samples the write. Until then, a read of the timer returns the old, still-running count.
- R4: While the action code is nonzero, the counter decreases by exactly one per clock. While the code is 0, it holds its value.
- R5: A counter at zero stays at zero until a timer write lands. The value 0xFFFFFFFF can be loaded and reads back unchanged.
- R6: With action 1 and the count at zero, irq_o is high and nmi_o is low. irq_o stays high until a timer write lands or the action becomes 0.
- R7: With action 2 and the count at zero, nmi_o is high and irq_o is low. nmi_o stays high until a timer write lands or the action becomes 0.
- R8: With action 3, chip_rst_req_o goes high one clock after the count reaches zero and stays high for exactly 16 cycles. It does not go high again while the block stays expired.
- R9: The reset-cause flag (control bit 31) is set by a chip-reset expiry. It stays set through a block reset on rst_n and is cleared only by por_n.
- R10: With action 0, no output is raised, even when the count is zero.
- R11: Writes to any address other than 0x00 and 0x04 change no state, and reads of such addresses return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Watchdog clock; one tick per edge |
| rst_n | input | 1 | Asynchronous active-low block reset |
| por_n | input | 1 | Asynchronous active-low power-on reset; the only clear of the reset-cause flag |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe; the write is sampled on the rising edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| irq_o | output | 1 | General-purpose interrupt level |
| nmi_o | output | 1 | Non-maskable interrupt level |
| chip_rst_req_o | output | 1 | Chip reset request pulse |

## Verification
The assertions assume that a write strobe lasts one clock and is sampled on a single edge. They also assume that rst_n is never released while por_n is still low, and that the reset-request pulse is not cut short by rst_n. The pulse-length check is disabled during block reset. The stimulus writes only from the falling edge, one access per cycle. It starts a block reset only after the 16-cycle request has ended. In the randomized phase it picks the action from codes 0 to 2 only, so each chip-reset expiry is a directed case with a known start edge.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    typedef enum logic [1:0] {
        ACT_NONE  = 2'd0,
        ACT_IRQ   = 2'd1,
        ACT_NMI   = 2'd2,
        ACT_RESET = 2'd3
    } wdog_act_e;

    localparam int CTRL_OFS  = 'h00;
    localparam int TIMER_OFS = 'h04;

endpackage

// File: rtl/wdog_load_pipe.sv
module wdog_load_pipe #(
    parameter int DW  = 32,
    parameter int LAT = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          in_vld,
    input  logic [DW-1:0] in_dat,
    output logic          out_vld,
    output logic [DW-1:0] out_dat
);

    generate
        if (LAT == 0) begin : g_bypass
            assign out_vld = in_vld;
            assign out_dat = in_dat;
        end else begin : g_pipe
            typedef struct packed {
                logic          vld;
                logic [DW-1:0] dat;
            } stage_t;

            stage_t [LAT-1:0] st_d, st_q;

            always_comb begin
                st_d[0] = '{vld: in_vld, dat: in_dat};
                for (int i = 1; i < LAT; i++) begin
                    st_d[i] = st_q[i-1];
                end
            end

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign out_vld = st_q[LAT-1].vld;
            assign out_dat = st_q[LAT-1].dat;
        end
    endgenerate

endmodule

// File: rtl/wdog_counter.sv
module wdog_counter
    import wdog_pkg::*;
#(
    parameter int DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  wdog_act_e     act,
    input  logic          load_vld,
    input  logic [DW-1:0] load_val,
    output logic [DW-1:0] cnt_o,
    output logic          zero_o
);

    typedef struct packed {
        logic [DW-1:0] cnt;
    } cnt_state_t;

    cnt_state_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (load_vld) begin
            s_d.cnt = load_val;
        end else if (act != ACT_NONE && s_q.cnt != '0) begin
            s_d.cnt = s_q.cnt - DW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cnt_o  = s_q.cnt;
    assign zero_o = (s_q.cnt == '0);

    a_r3_load_lands: assert property (@(posedge clk) disable iff (!rst_n)
        load_vld |=> cnt_o == $past(load_val));

    a_r4_step_down: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_vld && act != ACT_NONE && !zero_o) |=> cnt_o == $past(cnt_o) - DW'(1));

    a_r4_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_vld && act == ACT_NONE) |=> $stable(cnt_o));

    a_r5_zero_sticks: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_vld && zero_o) |=> zero_o);

endmodule

// File: rtl/wdog_expiry.sv
module wdog_expiry
    import wdog_pkg::*;
#(
    parameter int PULSE_LEN = 16
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por_n,
    input  wdog_act_e act,
    input  logic      zero,
    output logic      irq_o,
    output logic      nmi_o,
    output logic      rst_req_o,
    output logic      cause_o
);

    localparam int PW = $clog2(PULSE_LEN + 1);

    typedef struct packed {
        logic          fire_prev;
        logic [PW-1:0] pulse;
    } exp_state_t;

    exp_state_t s_d, s_q;
    logic       cause_d, cause_q;
    logic       fire, fire_evt;

    always_comb begin
        fire     = zero && (act == ACT_RESET);
        fire_evt = fire && !s_q.fire_prev;
        s_d.fire_prev = fire;
        if (fire_evt)               s_d.pulse = PW'(PULSE_LEN);
        else if (s_q.pulse != '0)   s_d.pulse = s_q.pulse - PW'(1);
        else                        s_d.pulse = '0;
        cause_d = cause_q | fire_evt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) cause_q <= 1'b0;
        else        cause_q <= cause_d;
    end

    assign irq_o     = zero && (act == ACT_IRQ);
    assign nmi_o     = zero && (act == ACT_NMI);
    assign rst_req_o = (s_q.pulse != '0);
    assign cause_o   = cause_q;

    // checker state: length of the current request run
    int unsigned hi_run;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         hi_run <= 0;
        else if (rst_req_o) hi_run <= hi_run + 1;
        else                hi_run <= 0;
    end

    a_r8_pulse_len: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_req_o) |-> hi_run == PULSE_LEN);

    a_r8_pulse_start: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_req_o) |-> ($past(zero) && $past(act) == ACT_RESET));

    a_r9_cause_sticky: assert property (@(posedge clk) disable iff (!por_n)
        cause_o |=> cause_o);

endmodule

// File: rtl/action_watchdog.sv
module action_watchdog
    import wdog_pkg::*;
#(
    parameter int DW        = 32,
    parameter int ADDR_W    = 8,
    parameter int LOAD_LAT  = 4,
    parameter int PULSE_LEN = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              irq_o,
    output logic              nmi_o,
    output logic              chip_rst_req_o
);

    localparam logic [ADDR_W-1:0] CTRL_ADDR  = ADDR_W'(CTRL_OFS);
    localparam logic [ADDR_W-1:0] TIMER_ADDR = ADDR_W'(TIMER_OFS);

    typedef struct packed {
        wdog_act_e act;
    } ctrl_state_t;

    ctrl_state_t r_d, r_q;
    logic        sel_ctrl, sel_timer;
    logic        ld_vld;
    logic [DW-1:0] ld_val;
    logic [DW-1:0] count;
    logic        zero;
    logic        cause;

    always_comb begin
        sel_ctrl  = bus_we && (bus_addr == CTRL_ADDR);
        sel_timer = bus_we && (bus_addr == TIMER_ADDR);
        r_d = r_q;
        if (sel_ctrl) r_d.act = wdog_act_e'(bus_wdata[1:0]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{act: ACT_NONE};
        else        r_q <= r_d;
    end

    wdog_load_pipe #(.DW(DW), .LAT(LOAD_LAT)) u_pipe (
        .clk     (clk),
        .rst_n   (rst_n),
        .in_vld  (sel_timer),
        .in_dat  (bus_wdata),
        .out_vld (ld_vld),
        .out_dat (ld_val)
    );

    wdog_counter #(.DW(DW)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .act      (r_q.act),
        .load_vld (ld_vld),
        .load_val (ld_val),
        .cnt_o    (count),
        .zero_o   (zero)
    );

    wdog_expiry #(.PULSE_LEN(PULSE_LEN)) u_exp (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_n     (por_n),
        .act       (r_q.act),
        .zero      (zero),
        .irq_o     (irq_o),
        .nmi_o     (nmi_o),
        .rst_req_o (chip_rst_req_o),
        .cause_o   (cause)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == CTRL_ADDR) begin
            bus_rdata[1:0]  = r_q.act;
            bus_rdata[DW-1] = cause;
        end else if (bus_addr == TIMER_ADDR) begin
            bus_rdata = count;
        end
    end

    a_r2_ctrl_write: assert property (@(posedge clk) disable iff (!rst_n)
        sel_ctrl |=> r_q.act == wdog_act_e'($past(bus_wdata[1:0])));

    a_r11_other_write: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr != CTRL_ADDR) |=> $stable(r_q.act));

endmodule

// File: tb/action_watchdog_bench.sv
module action_watchdog_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 4;
    localparam int PLEN       = 16;
    localparam logic [7:0] A_CTRL  = 8'h00;
    localparam logic [7:0] A_TIMER = 8'h04;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_n = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, nmi_o, chip_rst_req_o;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    action_watchdog u_action_watchdog (
        .clk(clk), .rst_n(rst_n), .por_n(por_n),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .nmi_o(nmi_o),
        .chip_rst_req_o(chip_rst_req_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [31:0] sat_sub(input logic [31:0] v, input int unsigned k);
        return (k >= v) ? 32'd0 : v - k;
    endfunction

    function automatic logic [2:0] exp_outs(input int a, input logic [31:0] cnt);
        // {rst_req, nmi, irq} for level outputs only
        return {1'b0, (a == 2 && cnt == 0), (a == 1 && cnt == 0)};
    endfunction

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: got 0x%08h expected 0x%08h", 0, 1);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int hi;
        void'($urandom(32'h5A17));
        step(3);
        por_n = 1'b1; rst_n = 1'b1;
        step(1);

        // R1 reset state
        rd(A_CTRL, d);  chk("R1 ctrl", d, 32'h0);
        rd(A_TIMER, d); chk("R1 timer", d, 32'h0);
        chk("R1 outs", {29'd0, chip_rst_req_o, nmi_o, irq_o}, 32'h0);

        // R11 unmapped access
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, d);   chk("R11 read", d, 32'h0);
        rd(A_CTRL, d);  chk("R11 ctrl", d, 32'h0);
        step(LAT);
        rd(A_TIMER, d); chk("R11 timer", d, 32'h0);

        // R2 ignored bits
        wr(A_CTRL, 32'hFFFF_FFFC);
        rd(A_CTRL, d);  chk("R2 bit31 ignored", d, 32'h0);
        wr(A_CTRL, 32'h7FFF_FFFD);
        rd(A_CTRL, d);  chk("R2 action field", d, 32'h1);
        wr(A_CTRL, 32'h0);

        // R3 latency, R4 idle hold
        wr(A_TIMER, 32'd100);
        rd(A_TIMER, d); chk("R3 old at write", d, 32'h0);
        step(LAT - 1);
        rd(A_TIMER, d); chk("R3 old before land", d, 32'h0);
        step(1);
        rd(A_TIMER, d); chk("R3 landed", d, 32'd100);
        step(5);
        rd(A_TIMER, d); chk("R4 hold action0", d, 32'd100);

        // R4 countdown, R6 irq
        wr(A_CTRL, 32'h1);
        rd(A_TIMER, d); chk("R4 start", d, 32'd100);
        step(10);
        rd(A_TIMER, d); chk("R4 minus 10", d, 32'd90);
        chk("R6 irq low", {31'd0, irq_o}, 32'h0);
        step(90);
        rd(A_TIMER, d); chk("R5 reached zero", d, 32'h0);
        chk("R6 outs", {29'd0, chip_rst_req_o, nmi_o, irq_o}, 32'h1);
        step(5);
        rd(A_TIMER, d); chk("R5 hold zero", d, 32'h0);
        wr(A_TIMER, 32'd20);
        step(LAT - 1);
        chk("R6 irq until land", {31'd0, irq_o}, 32'h1);
        step(1);
        chk("R6 irq cleared by reload", {31'd0, irq_o}, 32'h0);
        step(20);
        chk("R6 irq again", {31'd0, irq_o}, 32'h1);
        wr(A_CTRL, 32'h0);
        chk("R10 action0 clears irq", {29'd0, chip_rst_req_o, nmi_o, irq_o}, 32'h0);
        step(20);
        chk("R10 no outputs", {29'd0, chip_rst_req_o, nmi_o, irq_o}, 32'h0);

        // R7 nmi
        wr(A_CTRL, 32'h2);
        chk("R7 nmi at zero", {29'd0, chip_rst_req_o, nmi_o, irq_o}, 32'h2);
        wr(A_TIMER, 32'd5);
        step(LAT);
        chk("R7 nmi cleared by reload", {31'd0, nmi_o}, 32'h0);
        step(4);
        chk("R7 nmi before zero", {31'd0, nmi_o}, 32'h0);
        step(1);
        chk("R7 nmi at expiry", {29'd0, chip_rst_req_o, nmi_o, irq_o}, 32'h2);
        wr(A_CTRL, 32'h0);
        chk("R7 nmi cleared by action0", {31'd0, nmi_o}, 32'h0);

        // R8 reset pulse, R9 sticky cause
        wr(A_TIMER, 32'd30);
        step(LAT);
        wr(A_CTRL, 32'h3);
        step(30);
        chk("R8 no request at zero edge", {31'd0, chip_rst_req_o}, 32'h0);
        hi = 0;
        for (int i = 0; i < PLEN; i++) begin
            step(1);
            if (chip_rst_req_o) hi++;
            if (i == 0) begin
                rd(A_CTRL, d); chk("R9 cause set", d, 32'h8000_0003);
            end
        end
        chk("R8 pulse high cycles", hi, PLEN);
        step(1);
        chk("R8 pulse ended", {31'd0, chip_rst_req_o}, 32'h0);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            step(1);
            if (chip_rst_req_o) hi++;
        end
        chk("R8 single pulse", hi, 0);
        rst_n = 1'b0;
        step(2);
        rst_n = 1'b1;
        step(1);
        rd(A_CTRL, d);  chk("R9 survives rst_n", d, 32'h8000_0000);
        rd(A_TIMER, d); chk("R1 timer after rst_n", d, 32'h0);
        rst_n = 1'b0; por_n = 1'b0;
        step(2);
        por_n = 1'b1; rst_n = 1'b1;
        step(1);
        rd(A_CTRL, d);  chk("R9 cleared by por", d, 32'h0);

        // R5 full range
        wr(A_TIMER, 32'hFFFF_FFFF);
        step(LAT);
        rd(A_TIMER, d); chk("R5 full load", d, 32'hFFFF_FFFF);
        wr(A_CTRL, 32'h1);
        step(3);
        rd(A_TIMER, d); chk("R4 full minus 3", d, 32'hFFFF_FFFC);
        wr(A_CTRL, 32'h0);

        // randomized phase
        for (int it = 0; it < 40; it++) begin
            int a;
            int unsigned v, w, j, v2, dec;
            logic [31:0] e;
            a  = $urandom % 3;
            v  = 8 + ($urandom % 60);
            w  = $urandom % (v + 12);
            j  = $urandom % LAT;
            v2 = 1 + ($urandom % 200);
            dec = (a != 0) ? 1 : 0;
            wr(A_TIMER, v);
            step(LAT);
            wr(A_CTRL, a);
            step(w);
            e = sat_sub(v, w * dec);
            rd(A_TIMER, d); chk("R4 random count", d, e);
            chk("R6 R7 R10 random outs", {29'd0, chip_rst_req_o, nmi_o, irq_o},
                {29'd0, exp_outs(a, e)});
            wr(A_TIMER, v2);
            step(j);
            e = sat_sub(e, (1 + j) * dec);
            rd(A_TIMER, d); chk("R3 random old value", d, e);
            step(LAT - j);
            rd(A_TIMER, d); chk("R3 random landed", d, v2);
            wr(A_CTRL, 32'h0);
        end

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule